// File: doc/BRIEF.md
# Receive Frame Buffer Packer

This block sits between a receive byte stream and a 16-bit word-addressed packet buffer. Software or an allocator gives it a base word address with a start strobe. The block then packs the incoming bytes of one frame two to a word, starting two words above the base. When the frame's last byte arrives, it closes the image. It writes a trailing word that carries a control byte. It then goes back to fill in the byte count word at base+1 and the status word at base+0.

Only after the whole image is in memory does it raise a one-cycle done pulse and present the base address of the finished frame. It ignores further bytes until the next start strobe. The stored count is in bytes. It always comes out even, because it covers the two header words, the data and the control byte rounded up to a whole word. An odd data length is reported by a flag in the status word. Data beyond the largest image is dropped and flagged, and the header writes still complete.

Top module: `rx_frame_packer`

## Requirements
- R1: After reset, no write is issued, done is low and the reported frame base is zero.
- R2: Bytes presented while no frame is open produce no writes and no done pulse. A start strobe is accepted only when no frame is open, and it captures the base address. A start strobe during an open frame has no effect.
- R3: Data byte 2j lands in the low half (bits 7:0) and byte 2j+1 in the high half (bits 15:8) of word base+2+j. Every write drives both byte enables (be = 2'b11).
- R4: For an odd data length N, the final word holds the last data byte in its low half and the control byte in its high half. The control byte has bit 5 set and all other bits zero.
- R5: For an even data length N, an extra word 0x0000 (a control byte of zero in the high half, low half zero) is written at base+2+N/2.
- R6: The word at base+1 holds the byte count: 4+N+1 for odd N and 4+N+2 for even N. It is always even.
- R7: The word at base+0 is the end-of-frame status input, taken with the last byte. Bit 12 is replaced by the odd-length flag and bit 11 by the overflow flag.
- R8: Writes occur in the order data, trailing word, count word, status word, each lasting one cycle. The header words are written only after all data.
- R9: At most 1528 data bytes are stored, so the image never exceeds 1534 bytes. Further bytes are not written and set the overflow flag, and the frame still completes with count 1534.
- R10: Done is a one-cycle pulse in the cycle after the status word write, with the frame base output equal to that frame's base. A start strobe in the done cycle is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Opens a frame at base_i (only when idle) |
| base_i | input | AW | Base word address of the next frame |
| in_valid_i | input | 1 | A byte is present on in_data_i |
| in_data_i | input | 8 | Received byte |
| in_last_i | input | 1 | Marks the final byte of the frame |
| in_stat_i | input | 16 | End-of-frame status, sampled with the last byte |
| wr_en_o | output | 1 | Buffer write strobe |
| wr_addr_o | output | AW | Buffer word address |
| wr_data_o | output | 16 | Buffer write data |
| wr_be_o | output | 2 | Byte enables, bit 0 for the low byte |
| done_o | output | 1 | One-cycle frame completion pulse |
| frame_base_o | output | AW | Base address of the last completed frame |

## Verification
The completion pulse of one frame and the acceptance of the next frame's start strobe can fall in the same cycle. The bench provokes this by raising start with a new base in exactly the cycle where done is seen. Data bytes then follow without a gap. It judges the result by checking the second frame's full image and its own done pulse and base, and by confirming that the first frame's image and reported base are left intact.

// File: rtl/rxpk_pkg.sv
// Shared definitions for the receive frame packer.
// Assumes a 16-bit buffer word holding two bytes, low byte first.
package rxpk_pkg;
    typedef enum logic [2:0] {
        PH_IDLE,
        PH_RECV,
        PH_TAIL,
        PH_CNT,
        PH_STAT,
        PH_DONE
    } phase_t;

    localparam int ST_ODD_BIT   = 12;
    localparam int ST_OVF_BIT   = 11;
    localparam int CTRL_ODD_BIT = 5;
endpackage

// File: rtl/rxpk_seq.sv
// Frame sequencer: opens a frame on start, walks the closing phases
// (trailing word, count word, status word) and produces the done pulse.
// Assumes in_last_i is only meaningful together with in_valid_i.
module rxpk_seq
    import rxpk_pkg::*;
#(
    parameter int AW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic [AW-1:0] base_i,
    input  logic          in_valid_i,
    input  logic          in_last_i,
    output phase_t        phase_o,
    output logic          open_o,
    output logic [AW-1:0] base_o,
    output logic          done_o,
    output logic [AW-1:0] frame_base_o
);
    phase_t        phase_q;
    logic [AW-1:0] base_q;
    logic          done_q;
    logic [AW-1:0] fbase_q;

    assign open_o = (phase_q == PH_IDLE) && start_i;

    // Phase progression for one frame
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
        end else begin
            case (phase_q)
                PH_IDLE: if (start_i) phase_q <= PH_RECV;
                PH_RECV: if (in_valid_i && in_last_i) phase_q <= PH_TAIL;
                PH_TAIL: phase_q <= PH_CNT;
                PH_CNT:  phase_q <= PH_STAT;
                PH_STAT: phase_q <= PH_DONE;
                default: phase_q <= PH_IDLE;
            endcase
        end
    end

    // Base capture on an accepted start strobe
    always_ff @(posedge clk) begin
        if (!rst_n) base_q <= '0;
        else if (open_o) base_q <= base_i;
    end

    // Done pulse and reported base, one cycle after the status write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q  <= 1'b0;
            fbase_q <= '0;
        end else begin
            done_q <= (phase_q == PH_DONE);
            if (phase_q == PH_DONE) fbase_q <= base_q;
        end
    end

    assign phase_o      = phase_q;
    assign base_o       = base_q;
    assign done_o       = done_q;
    assign frame_base_o = fbase_q;
endmodule

// File: rtl/rxpk_lane.sv
// Byte lane assembler: holds the even byte, forms a full word on the odd
// byte, counts stored bytes, enforces the length limit and latches status.
// Assumes bytes arrive only while the sequencer is in the receive phase.
module rxpk_lane
    import rxpk_pkg::*;
#(
    parameter int MAX_DATA = 1528,
    parameter int CW       = 11
) (
    input  logic          clk,
    input  logic          rst_n,
    input  phase_t        phase_i,
    input  logic          open_i,
    input  logic          in_valid_i,
    input  logic [7:0]    in_data_i,
    input  logic          in_last_i,
    input  logic [15:0]   in_stat_i,
    output logic          pair_fire_o,
    output logic [15:0]   pair_word_o,
    output logic [CW-1:0] cnt_o,
    output logic [7:0]    hold_o,
    output logic          ovf_o,
    output logic [15:0]   stat_o
);
    logic [CW-1:0] cnt_q;
    logic [7:0]    hold_q;
    logic          ovf_q;
    logic [15:0]   stat_q;
    logic          accept;
    logic          keep;

    assign accept      = (phase_i == PH_RECV) && in_valid_i;
    assign keep        = accept && (cnt_q < CW'(MAX_DATA));
    assign pair_fire_o = keep && cnt_q[0];
    assign pair_word_o = {in_data_i, hold_q};

    // Byte counting, low-byte holding and overflow tracking
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            hold_q <= '0;
            ovf_q  <= 1'b0;
        end else if (open_i) begin
            cnt_q  <= '0;
            hold_q <= '0;
            ovf_q  <= 1'b0;
        end else if (keep) begin
            cnt_q <= cnt_q + CW'(1);
            if (!cnt_q[0]) hold_q <= in_data_i;
        end else if (accept) begin
            ovf_q <= 1'b1;
        end
    end

    // End-of-frame status capture with the last byte
    always_ff @(posedge clk) begin
        if (!rst_n) stat_q <= '0;
        else if (accept && in_last_i) stat_q <= in_stat_i;
    end

    assign cnt_o  = cnt_q;
    assign hold_o = hold_q;
    assign ovf_o  = ovf_q;
    assign stat_o = stat_q;
endmodule

// File: rtl/rxpk_wport.sv
// Registered write port: selects between a packed data word, the trailing
// control word, the count word and the status word for each cycle.
// Assumes at most one source is active per cycle (guaranteed by phases).
module rxpk_wport
    import rxpk_pkg::*;
#(
    parameter int AW = 10,
    parameter int CW = 11
) (
    input  logic          clk,
    input  logic          rst_n,
    input  phase_t        phase_i,
    input  logic [AW-1:0] base_i,
    input  logic          pair_fire_i,
    input  logic [15:0]   pair_word_i,
    input  logic [CW-1:0] cnt_i,
    input  logic [7:0]    hold_i,
    input  logic          ovf_i,
    input  logic [15:0]   stat_i,
    output logic          wr_en_o,
    output logic [AW-1:0] wr_addr_o,
    output logic [15:0]   wr_data_o,
    output logic [1:0]    wr_be_o
);
    logic          odd;
    logic [AW-1:0] data_addr;
    logic [7:0]    ctrl_byte;
    logic [15:0]   count_word;
    logic [15:0]   status_word;
    logic          nx_en;
    logic [AW-1:0] nx_addr;
    logic [15:0]   nx_data;

    assign odd        = cnt_i[0];
    assign data_addr  = base_i + AW'(2) + AW'(cnt_i >> 1);
    assign count_word = 16'(cnt_i) + 16'd4 + (odd ? 16'd1 : 16'd2);

    // Control byte and status word composition
    always_comb begin
        ctrl_byte                = '0;
        ctrl_byte[CTRL_ODD_BIT]  = odd;
        status_word              = stat_i;
        status_word[ST_ODD_BIT]  = odd;
        status_word[ST_OVF_BIT]  = ovf_i;
    end

    // Next write selection
    always_comb begin
        nx_en   = 1'b0;
        nx_addr = '0;
        nx_data = '0;
        if (pair_fire_i) begin
            nx_en   = 1'b1;
            nx_addr = data_addr;
            nx_data = pair_word_i;
        end else begin
            case (phase_i)
                PH_TAIL: begin
                    nx_en   = 1'b1;
                    nx_addr = data_addr;
                    nx_data = {ctrl_byte, odd ? hold_i : 8'h00};
                end
                PH_CNT: begin
                    nx_en   = 1'b1;
                    nx_addr = base_i + AW'(1);
                    nx_data = count_word;
                end
                PH_STAT: begin
                    nx_en   = 1'b1;
                    nx_addr = base_i;
                    nx_data = status_word;
                end
                default: nx_en = 1'b0;
            endcase
        end
    end

    // Output registers of the buffer write port
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_en_o   <= 1'b0;
            wr_addr_o <= '0;
            wr_data_o <= '0;
            wr_be_o   <= '0;
        end else begin
            wr_en_o   <= nx_en;
            wr_addr_o <= nx_addr;
            wr_data_o <= nx_data;
            wr_be_o   <= nx_en ? 2'b11 : 2'b00;
        end
    end
endmodule

// File: rtl/rx_frame_packer.sv
// Receive frame packer top: stores one received frame per start strobe as
// status word, count word, packed data and trailing control byte.
// Assumes the buffer region at the base is free for up to MAX_IMAGE bytes.
module rx_frame_packer
    import rxpk_pkg::*;
#(
    parameter int AW        = 10,
    parameter int MAX_IMAGE = 1534
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic [AW-1:0] base_i,
    input  logic          in_valid_i,
    input  logic [7:0]    in_data_i,
    input  logic          in_last_i,
    input  logic [15:0]   in_stat_i,
    output logic          wr_en_o,
    output logic [AW-1:0] wr_addr_o,
    output logic [15:0]   wr_data_o,
    output logic [1:0]    wr_be_o,
    output logic          done_o,
    output logic [AW-1:0] frame_base_o
);
    localparam int MAX_DATA = MAX_IMAGE - 6;
    localparam int CW       = $clog2(MAX_DATA + 1);

    phase_t        phase;
    logic          open_frame;
    logic [AW-1:0] base_q;
    logic          pair_fire;
    logic [15:0]   pair_word;
    logic [CW-1:0] cnt;
    logic [7:0]    hold;
    logic          ovf;
    logic [15:0]   stat;

    rxpk_seq #(.AW(AW)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .base_i      (base_i),
        .in_valid_i  (in_valid_i),
        .in_last_i   (in_last_i),
        .phase_o     (phase),
        .open_o      (open_frame),
        .base_o      (base_q),
        .done_o      (done_o),
        .frame_base_o(frame_base_o)
    );

    rxpk_lane #(.MAX_DATA(MAX_DATA), .CW(CW)) u_lane (
        .clk        (clk),
        .rst_n      (rst_n),
        .phase_i    (phase),
        .open_i     (open_frame),
        .in_valid_i (in_valid_i),
        .in_data_i  (in_data_i),
        .in_last_i  (in_last_i),
        .in_stat_i  (in_stat_i),
        .pair_fire_o(pair_fire),
        .pair_word_o(pair_word),
        .cnt_o      (cnt),
        .hold_o     (hold),
        .ovf_o      (ovf),
        .stat_o     (stat)
    );

    rxpk_wport #(.AW(AW), .CW(CW)) u_wport (
        .clk        (clk),
        .rst_n      (rst_n),
        .phase_i    (phase),
        .base_i     (base_q),
        .pair_fire_i(pair_fire),
        .pair_word_i(pair_word),
        .cnt_i      (cnt),
        .hold_i     (hold),
        .ovf_i      (ovf),
        .stat_i     (stat),
        .wr_en_o    (wr_en_o),
        .wr_addr_o  (wr_addr_o),
        .wr_data_o  (wr_data_o),
        .wr_be_o    (wr_be_o)
    );
endmodule

// File: rtl/rxpk_chk.sv
// Property checker for the receive frame packer, bound to the top.
module rxpk_chk
    import rxpk_pkg::*;
#(
    parameter int AW        = 10,
    parameter int MAX_IMAGE = 1534
) (
    input logic          clk,
    input logic          rst_n,
    input logic          wr_en_o,
    input logic [AW-1:0] wr_addr_o,
    input logic [15:0]   wr_data_o,
    input logic [1:0]    wr_be_o,
    input logic          done_o,
    input logic [AW-1:0] frame_base_o,
    input logic [AW-1:0] base_q,
    input phase_t        phase
);
    localparam int MAX_WORDS = MAX_IMAGE / 2;

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R8
    done_after_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> ($past(wr_en_o) && ($past(wr_addr_o) == frame_base_o) && !wr_en_o));

    // R3
    full_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_o |-> (wr_be_o == 2'b11));

    // R6
    count_even_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_o && (wr_addr_o == base_q + AW'(1))) |->
            (!wr_data_o[0] && (wr_data_o <= 16'(MAX_IMAGE)) && (wr_data_o >= 16'd6)));

    // R2
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_IDLE) |-> !wr_en_o);

    // R9
    span_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_o |-> ((wr_addr_o - base_q) < AW'(MAX_WORDS)));
endmodule

bind rx_frame_packer rxpk_chk #(.AW(AW), .MAX_IMAGE(MAX_IMAGE)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en_o     (wr_en_o),
    .wr_addr_o   (wr_addr_o),
    .wr_data_o   (wr_data_o),
    .wr_be_o     (wr_be_o),
    .done_o      (done_o),
    .frame_base_o(frame_base_o),
    .base_q      (base_q),
    .phase       (phase)
);

// File: tb/rx_frame_packer_test.sv
// Self-checking bench for the receive frame packer.
module rx_frame_packer_test;
    localparam int AW       = 10;
    localparam int MAXIMG   = 1534;
    localparam int MAXDATA  = MAXIMG - 6;
    localparam int NVEC     = 6;
    // {base, length, first byte, status low byte, gap}
    localparam logic [55:0] VEC [NVEC] = '{
        {16'd0,    16'd1,  8'h11, 8'h01, 8'd0},
        {16'd20,   16'd2,  8'h22, 8'h02, 8'd0},
        {16'd40,   16'd7,  8'h30, 8'h03, 8'd1},
        {16'd100,  16'd64, 8'h80, 8'h04, 8'd0},
        {16'd1000, 16'd60, 8'hF0, 8'h05, 8'd0},
        {16'd300,  16'd3,  8'h7E, 8'h06, 8'd2}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic [AW-1:0] base_i = '0;
    logic          in_valid_i = 1'b0;
    logic [7:0]    in_data_i = '0;
    logic          in_last_i = 1'b0;
    logic [15:0]   in_stat_i = '0;
    logic          wr_en_o;
    logic [AW-1:0] wr_addr_o;
    logic [15:0]   wr_data_o;
    logic [1:0]    wr_be_o;
    logic          done_o;
    logic [AW-1:0] frame_base_o;

    int errors = 0;
    int checks = 0;
    int wr_cnt = 0;
    int done_cnt = 0;
    logic done_order_ok = 1'b0;
    logic [15:0] mem [1 << AW];
    logic          p1_en = 1'b0, p2_en = 1'b0;
    logic [AW-1:0] p1_a = '0, p2_a = '0;
    logic          finished = 1'b0;

    rx_frame_packer #(.AW(AW), .MAX_IMAGE(MAXIMG)) uut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .base_i(base_i),
        .in_valid_i(in_valid_i), .in_data_i(in_data_i), .in_last_i(in_last_i),
        .in_stat_i(in_stat_i), .wr_en_o(wr_en_o), .wr_addr_o(wr_addr_o),
        .wr_data_o(wr_data_o), .wr_be_o(wr_be_o), .done_o(done_o),
        .frame_base_o(frame_base_o)
    );

    always #10 clk = ~clk;

    // Buffer model and done/order observer, sampled mid-cycle
    always @(negedge clk) begin
        if (wr_en_o) begin
            wr_cnt++;
            if (wr_be_o[0]) mem[wr_addr_o][7:0]  = wr_data_o[7:0];
            if (wr_be_o[1]) mem[wr_addr_o][15:8] = wr_data_o[15:8];
        end
        if (done_o) begin
            done_cnt++;
            done_order_ok = p1_en && (p1_a == frame_base_o) && p2_en &&
                            (p2_a == frame_base_o + AW'(1)) && !wr_en_o;
        end
        p2_en = p1_en; p2_a = p1_a;
        p1_en = wr_en_o; p1_a = wr_addr_o;
    end

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic clear_mem();
        for (int i = 0; i < (1 << AW); i++) mem[i] = 16'hDEAD;
    endtask

    task automatic open_frame(input int base);
        @(negedge clk);
        start_i = 1'b1; base_i = AW'(base);
        @(negedge clk);
        start_i = 1'b0;
    endtask

    // Drives len bytes from first upward; optional mid-frame start strobe
    task automatic push_bytes(input int len, input logic [7:0] first, input logic [15:0] st,
                              input int gap, input logic midstart);
        for (int i = 0; i < len; i++) begin
            in_valid_i = 1'b1;
            in_data_i  = first + 8'(i);
            in_last_i  = (i == len - 1);
            in_stat_i  = st;
            start_i    = midstart && (i == len / 2);
            base_i     = midstart ? AW'(500) : base_i;
            @(negedge clk);
            in_valid_i = 1'b0; in_last_i = 1'b0; start_i = 1'b0;
            for (int g = 0; g < gap; g++) @(negedge clk);
        end
    endtask

    // Returns at the negedge where done is high
    task automatic wait_done(input string req);
        for (int i = 0; i < 20; i++) begin
            if (done_o) return;
            @(negedge clk);
        end
        chk(req, "done timeout", 0, 1);
    endtask

    task automatic check_frame(input int base, input int len, input logic [7:0] first,
                               input logic [15:0] st);
        int nn, cnt, bad;
        logic odd, ovf;
        logic [7:0] ctrl, hi;
        logic [15:0] exp;
        nn  = (len > MAXDATA) ? MAXDATA : len;
        ovf = (len > MAXDATA);
        odd = nn[0];
        ctrl = odd ? 8'h20 : 8'h00;
        cnt = 4 + nn + (odd ? 1 : 2);
        exp = st;
        exp[12] = odd; exp[11] = ovf;
        chk(ovf ? "R9" : "R7", "status word", 32'(mem[AW'(base)]), 32'(exp));
        chk(ovf ? "R9" : "R6", "count word", 32'(mem[AW'(base + 1)]), 32'(cnt));
        bad = 0;
        for (int j = 0; j < nn / 2; j++) begin
            exp = {first + 8'(2 * j + 1), first + 8'(2 * j)};
            if (mem[AW'(base + 2 + j)] !== exp) bad++;
        end
        chk("R3", "data words mismatching", 32'(bad), 0);
        hi = first + 8'(nn - 1);
        exp = odd ? {ctrl, hi} : 16'h0000;
        chk(odd ? "R4" : "R5", "trailing word", 32'(mem[AW'(base + 2 + nn / 2)]), 32'(exp));
        chk("R8", "word after image untouched", 32'(mem[AW'(base + 3 + nn / 2)]), 32'h0000DEAD);
    endtask

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=expired expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        clear_mem();
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1", "wr_en after reset", 32'(wr_en_o), 0);
        chk("R1", "done after reset", 32'(done_o), 0);
        chk("R1", "frame base after reset", 32'(frame_base_o), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 bytes without a start are ignored
        push_bytes(5, 8'h55, 16'h0, 0, 1'b0);
        repeat (6) @(negedge clk);
        chk("R2", "writes while idle", 32'(wr_cnt), 0);
        chk("R2", "done while idle", 32'(done_cnt), 0);

        // Table-driven frames
        for (int v = 0; v < NVEC; v++) begin
            int base, len, gap, dn;
            logic [7:0] first;
            logic [15:0] st;
            base  = int'(VEC[v][55:40]);
            len   = int'(VEC[v][39:24]);
            first = VEC[v][23:16];
            st    = {8'hFF, VEC[v][15:8]};
            gap   = int'(VEC[v][7:0]);
            clear_mem();
            dn = done_cnt;
            open_frame(base);
            push_bytes(len, first, st, gap, 1'b0);
            wait_done("R10");
            @(negedge clk);
            check_frame(base, len, first, st);
            chk("R10", "done pulses", 32'(done_cnt - dn), 1);
            chk("R10", "frame base", 32'(frame_base_o), 32'(base));
            chk("R8", "count then status before done", 32'(done_order_ok), 1);
        end

        // R2 start strobe during an open frame has no effect
        clear_mem();
        open_frame(200);
        push_bytes(6, 8'h40, 16'h1234, 0, 1'b1);
        wait_done("R2");
        chk("R2", "base kept despite mid-frame start", 32'(frame_base_o), 200);
        @(negedge clk);
        check_frame(200, 6, 8'h40, 16'h1234);
        chk("R2", "nothing at ignored base", 32'(mem[500]), 32'h0000DEAD);

        // R9 overflow: 1531 bytes, three are dropped
        clear_mem();
        open_frame(0);
        push_bytes(MAXDATA + 3, 8'h01, 16'h0000, 0, 1'b0);
        wait_done("R9");
        @(negedge clk);
        check_frame(0, MAXDATA + 3, 8'h01, 16'h0000);
        chk("R9", "count at limit", 32'(mem[1]), MAXIMG);

        // R10 start accepted in the done cycle, bytes follow at once
        clear_mem();
        open_frame(50);
        push_bytes(5, 8'hA0, 16'h0042, 0, 1'b0);
        wait_done("R10");
        chk("R10", "first frame base", 32'(frame_base_o), 50);
        start_i = 1'b1; base_i = AW'(80);
        @(negedge clk);
        start_i = 1'b0;
        push_bytes(4, 8'hC0, 16'h0007, 0, 1'b0);
        wait_done("R10");
        chk("R10", "second frame base", 32'(frame_base_o), 80);
        @(negedge clk);
        check_frame(50, 5, 8'hA0, 16'h0042);
        check_frame(80, 4, 8'hC0, 16'h0007);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule